// File: doc/BRIEF.md
# Display Raster Timing Generator

The block turns a dot clock into the timing of a raster display. It produces horizontal and vertical sync, horizontal and vertical blanking, and a display-enable strobe. It also brings out its three counters: the dot position within the current character, the character position within the scanline, and the scanline within the frame. The horizontal axis is counted in characters of 8 or 9 dots, and the vertical axis is counted in scanlines.

Each start point is programmed as the last unit before its period begins. The blanking and sync periods do not end on a full comparison. A period ends after the unit whose low counter bits equal a short end field, and that unit is included in the period. As a result, a period may run past the counter wrap and carry into the next scanline or the next frame.

All timing inputs are captured into a shadow set in two cases: during reset, and on the last dot of each frame. Changing an input in the middle of a frame therefore leaves the frame in progress unchanged.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied, `dot_cnt`, `char_cnt`, `line_cnt`, `hblank`, `hsync`, `vblank` and `vsync` are 0 and `disp_en` is 1.
- R2: `dot_cnt` counts 0 to 7 when `dot8_sel` is 1 and 0 to 8 when `dot8_sel` is 0. `char_cnt` advances when `dot_cnt` returns to 0.
- R3: A scanline holds `h_total`+5 characters. `char_cnt` runs from 0 to `h_total`+4 and then wraps to 0.
- R4: A frame holds `v_total`+1 scanlines. `line_cnt` advances when `char_cnt` wraps, runs from 0 to `v_total`, and then wraps to 0.
- R5: `disp_en` is 1 exactly when `char_cnt` ≤ `h_disp_last` and `line_cnt` ≤ `v_disp_last`.
- R6: `hblank` rises on the character after `h_blank_from`. It falls after the first later character whose `char_cnt[5:0]` equals `h_blank_stop`. The length in characters is (`h_blank_stop` − `h_blank_from`) mod 64, where 0 means 64.
- R7: `hsync` rises on the character after `h_sync_from`. It falls after the first later character whose `char_cnt[4:0]` equals `h_sync_stop`. The length is 1 to 32 characters.
- R8: `vblank` and `vsync` follow the same rule in scanlines, matching `line_cnt[6:0]` against `v_blank_stop` and `line_cnt[3:0]` against `v_sync_stop`. They change only at the first dot of a scanline.
- R9: A blanking or sync period that reaches the counter wrap stays active into the next scanline or frame until its end match occurs.
- R10: Timing inputs, including `dot8_sel`, take effect only from the first dot of the next frame. The frame in progress keeps the values that were captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low; also captures the timing inputs |
| dot8_sel | input | 1 | 1: characters of 8 dots; 0: characters of 9 dots |
| h_total | input | HW | Characters per scanline minus 5 |
| h_disp_last | input | HW | Last displayed character |
| h_blank_from | input | HW | Character after which horizontal blanking begins |
| h_blank_stop | input | 6 | Low 6 bits of the last blanked character |
| h_sync_from | input | HW | Character after which horizontal sync begins |
| h_sync_stop | input | 5 | Low 5 bits of the last sync character |
| v_total | input | VW | Scanlines per frame minus 1 |
| v_disp_last | input | VW | Last displayed scanline |
| v_blank_from | input | VW | Scanline after which vertical blanking begins |
| v_blank_stop | input | 7 | Low 7 bits of the last blanked scanline |
| v_sync_from | input | VW | Scanline after which vertical sync begins |
| v_sync_stop | input | 4 | Low 4 bits of the last sync scanline |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Active picture area |
| char_cnt | output | HW+1 | Character within scanline |
| dot_cnt | output | 4 | Dot within character |
| line_cnt | output | VW | Scanline within frame |

## Verification
Every output is either a register or decoded from registers, so a new value appears right after the rising edge that causes it. The horizontal flags take effect on the character following the one where the decision is made. The vertical flags take effect on the first dot of the following scanline. A changed timing input takes effect on the first dot after the current frame's last dot. The bench samples only on falling edges and measures whole scanlines and frames from one counter origin to the next, so each observed length already includes that latency. To check the frame-boundary capture, the bench changes inputs mid-frame, measures the scanline that follows, and then measures the next whole frame.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot8_sel,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_disp_last,
  input  logic [HW-1:0] h_blank_from,
  input  logic [5:0]    h_blank_stop,
  input  logic [HW-1:0] h_sync_from,
  input  logic [4:0]    h_sync_stop,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_disp_last,
  input  logic [VW-1:0] v_blank_from,
  input  logic [6:0]    v_blank_stop,
  input  logic [VW-1:0] v_sync_from,
  input  logic [3:0]    v_sync_stop,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          disp_en,
  output logic [HW:0]   char_cnt,
  output logic [3:0]    dot_cnt,
  output logic [VW-1:0] line_cnt
);
  localparam int CW = HW + 1;
  localparam logic [CW-1:0] LINE_PAD = CW'(4);

  logic          dot8_q;
  logic [HW-1:0] ht_q, hde_q, hbs_q, hss_q;
  logic [5:0]    hbe_q;
  logic [4:0]    hse_q;
  logic [VW-1:0] vt_q, vde_q, vbs_q, vss_q;
  logic [6:0]    vbe_q;
  logic [3:0]    vse_q;

  logic [CW-1:0] char_last;
  logic char_end, line_end, frame_end;
  logic hb_nxt, hs_nxt, vb_nxt, vs_nxt;

  assign char_last = {1'b0, ht_q} + LINE_PAD;
  assign char_end  = dot_cnt == (dot8_q ? 4'd7 : 4'd8);
  assign line_end  = char_end && (char_cnt == char_last);
  assign frame_end = line_end && (line_cnt == vt_q);

  assign hb_nxt = (hblank && (char_cnt[5:0] != hbe_q)) || (char_cnt == {1'b0, hbs_q});
  assign hs_nxt = (hsync  && (char_cnt[4:0] != hse_q)) || (char_cnt == {1'b0, hss_q});
  assign vb_nxt = (vblank && (line_cnt[6:0] != vbe_q)) || (line_cnt == vbs_q);
  assign vs_nxt = (vsync  && (line_cnt[3:0] != vse_q)) || (line_cnt == vss_q);

  assign disp_en = (char_cnt <= {1'b0, hde_q}) && (line_cnt <= vde_q);

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      dot8_q <= dot8_sel;
      ht_q   <= h_total;
      hde_q  <= h_disp_last;
      hbs_q  <= h_blank_from;
      hbe_q  <= h_blank_stop;
      hss_q  <= h_sync_from;
      hse_q  <= h_sync_stop;
      vt_q   <= v_total;
      vde_q  <= v_disp_last;
      vbs_q  <= v_blank_from;
      vbe_q  <= v_blank_stop;
      vss_q  <= v_sync_from;
      vse_q  <= v_sync_stop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_cnt  <= '0;
      char_cnt <= '0;
      line_cnt <= '0;
      hblank   <= 1'b0;
      hsync    <= 1'b0;
      vblank   <= 1'b0;
      vsync    <= 1'b0;
    end else begin
      dot_cnt <= char_end ? 4'd0 : dot_cnt + 4'd1;
      if (char_end) begin
        char_cnt <= line_end ? '0 : char_cnt + CW'(1);
        hblank   <= hb_nxt;
        hsync    <= hs_nxt;
      end
      if (line_end) begin
        line_cnt <= frame_end ? '0 : line_cnt + VW'(1);
        vblank   <= vb_nxt;
        vsync    <= vs_nxt;
      end
    end
  end
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync,
  input logic          vsync,
  input logic          hblank,
  input logic          vblank,
  input logic [HW:0]   char_cnt,
  input logic [3:0]    dot_cnt,
  input logic [VW-1:0] line_cnt
);
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dot_cnt == 4'd0 && char_cnt == '0 && line_cnt == '0 &&
                      !hblank && !hsync && !vblank && !vsync));

  assert_dot_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dot_cnt <= 4'd8);

  assert_char_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_cnt != 4'd0) |-> $stable(char_cnt));

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_cnt != '0) |-> $stable(line_cnt));

  assert_hblank_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_cnt != 4'd0) |-> $stable(hblank));

  assert_hsync_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_cnt != 4'd0) |-> $stable(hsync));

  assert_vflags_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_cnt != 4'd0 || char_cnt != '0) |-> ($stable(vblank) && $stable(vsync)));
endmodule

bind raster_timing_gen raster_timing_chk #(.HW(HW), .VW(VW)) i_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .hblank(hblank),
  .vblank(vblank), .char_cnt(char_cnt), .dot_cnt(dot_cnt), .line_cnt(line_cnt)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dot8_sel;
  logic [7:0] h_total, h_disp_last, h_blank_from, h_sync_from;
  logic [5:0] h_blank_stop;
  logic [4:0] h_sync_stop;
  logic [9:0] v_total, v_disp_last, v_blank_from, v_sync_from;
  logic [6:0] v_blank_stop;
  logic [3:0] v_sync_stop;
  logic hsync, vsync, hblank, vblank, disp_en;
  logic [8:0] char_cnt;
  logic [3:0] dot_cnt;
  logic [9:0] line_cnt;

  always #2.5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .dot8_sel(dot8_sel),
    .h_total(h_total), .h_disp_last(h_disp_last), .h_blank_from(h_blank_from),
    .h_blank_stop(h_blank_stop), .h_sync_from(h_sync_from), .h_sync_stop(h_sync_stop),
    .v_total(v_total), .v_disp_last(v_disp_last), .v_blank_from(v_blank_from),
    .v_blank_stop(v_blank_stop), .v_sync_from(v_sync_from), .v_sync_stop(v_sync_stop),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank), .disp_en(disp_en),
    .char_cnt(char_cnt), .dot_cnt(dot_cnt), .line_cnt(line_cnt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    int dot8; int ht; int hde; int hbs; int hbe; int hss; int hse;
    int e_dots; int e_de; int e_hb; int e_hs; int e_hbr; int e_hsr; int e_maxdot; int e_maxchar;
  } hvec_t;

  localparam int NV = 5;
  localparam hvec_t HTAB [NV] = '{
    '{1, 95, 79, 80,  2, 84,  0, 800, 640, 176,  96, 81, 85, 7, 99},
    '{0, 20, 15, 16, 22, 18, 20, 225, 144,  54,  18, 17, 19, 8, 24},
    '{1, 95,  9, 10, 10, 20, 20, 800,  80, 512, 256, 11, 21, 7, 99},
    '{0, 10,  4,  5,  6,  7,  8, 135,  45,   9,   9,  6,  8, 8, 14},
    '{1, 15, 11, 12,  1, 17,  2, 160,  96,  72,  40, 13, 18, 7, 19}
  };

  int m_dots, m_de, m_hb, m_hs, m_hbr, m_hsr, m_maxdot, m_maxchar;
  int f_dots, f_lines, f_vb, f_vs, f_de, f_maxline;

  task automatic set_v(int vt, int vde, int vbs, int vbe, int vss, int vse);
    v_total = 10'(vt); v_disp_last = 10'(vde); v_blank_from = 10'(vbs);
    v_blank_stop = 7'(vbe); v_sync_from = 10'(vss); v_sync_stop = 4'(vse);
  endtask

  task automatic set_h(int d8, int ht, int hde, int hbs, int hbe, int hss, int hse);
    dot8_sel = d8[0]; h_total = 8'(ht); h_disp_last = 8'(hde); h_blank_from = 8'(hbs);
    h_blank_stop = 6'(hbe); h_sync_from = 8'(hss); h_sync_stop = 5'(hse);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_line_start();
    do @(negedge clk); while (!(char_cnt == 9'd0 && dot_cnt == 4'd0));
  endtask

  task automatic wait_frame_start();
    do @(negedge clk); while (!(line_cnt == 10'd0 && char_cnt == 9'd0 && dot_cnt == 4'd0));
  endtask

  task automatic measure_line();
    logic pb, ps;
    m_dots = 0; m_de = 0; m_hb = 0; m_hs = 0; m_hbr = -1; m_hsr = -1; m_maxdot = 0; m_maxchar = 0;
    pb = hblank; ps = hsync;
    do begin
      m_dots++;
      if (disp_en) m_de++;
      if (hblank) m_hb++;
      if (hsync) m_hs++;
      if (hblank && !pb && m_hbr < 0) m_hbr = int'(char_cnt);
      if (hsync && !ps && m_hsr < 0) m_hsr = int'(char_cnt);
      pb = hblank; ps = hsync;
      if (int'(dot_cnt) > m_maxdot) m_maxdot = int'(dot_cnt);
      if (int'(char_cnt) > m_maxchar) m_maxchar = int'(char_cnt);
      @(negedge clk);
    end while (!(char_cnt == 9'd0 && dot_cnt == 4'd0));
  endtask

  task automatic measure_frame();
    f_dots = 0; f_lines = 0; f_vb = 0; f_vs = 0; f_de = 0; f_maxline = 0;
    do begin
      f_dots++;
      if (disp_en) f_de++;
      if (char_cnt == 9'd0 && dot_cnt == 4'd0) begin
        f_lines++;
        if (vblank) f_vb++;
        if (vsync) f_vs++;
      end
      if (int'(line_cnt) > f_maxline) f_maxline = int'(line_cnt);
      @(negedge clk);
    end while (!(line_cnt == 10'd0 && char_cnt == 9'd0 && dot_cnt == 4'd0));
  endtask

  task automatic check_reset_state(string tag);
    check({tag, " R1 dot_cnt"}, int'(dot_cnt), 0);
    check({tag, " R1 char_cnt"}, int'(char_cnt), 0);
    check({tag, " R1 line_cnt"}, int'(line_cnt), 0);
    check({tag, " R1 flags"}, int'({hblank, hsync, vblank, vsync}), 0);
    check({tag, " R1 disp_en"}, int'(disp_en), 1);
  endtask

  initial begin
    #(150000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    set_h(1, 95, 79, 80, 2, 84, 0);
    set_v(20, 15, 16, 18, 16, 17);
    repeat (3) @(negedge clk);
    check_reset_state("initial");

    for (int i = 0; i < NV; i++) begin
      hvec_t v;
      v = HTAB[i];
      rst_n = 1'b0;
      set_h(v.dot8, v.ht, v.hde, v.hbs, v.hbe, v.hss, v.hse);
      set_v(20, 15, 16, 18, 16, 17);
      do_reset();
      wait_line_start();
      measure_line();
      check($sformatf("vec%0d R3 line dots", i), m_dots, v.e_dots);
      check($sformatf("vec%0d R3 max char", i), m_maxchar, v.e_maxchar);
      check($sformatf("vec%0d R2 max dot", i), m_maxdot, v.e_maxdot);
      check($sformatf("vec%0d R5 display dots", i), m_de, v.e_de);
      check($sformatf("vec%0d R6 hblank dots", i), m_hb, v.e_hb);
      check($sformatf("vec%0d R6 hblank first char", i), m_hbr, v.e_hbr);
      check($sformatf("vec%0d R7 hsync dots", i), m_hs, v.e_hs);
      check($sformatf("vec%0d R7 hsync first char", i), m_hsr, v.e_hsr);
    end

    // R9 carry check on vec4 shape: hblank/hsync still high on char 0 of a new line
    rst_n = 1'b0;
    set_h(1, 15, 11, 12, 1, 17, 2);
    do_reset();
    wait_line_start();
    check("R9 hblank carried across wrap", int'(hblank), 1);
    check("R9 hsync carried across wrap", int'(hsync), 1);

    // vertical timing, 40-dot lines
    rst_n = 1'b0;
    set_h(1, 0, 3, 3, 4, 3, 4);
    set_v(39, 29, 30, 35, 32, 33);
    do_reset();
    wait_frame_start();
    measure_frame();
    check("R4 frame dots", f_dots, 1600);
    check("R4 lines per frame", f_lines, 40);
    check("R4 max line", f_maxline, 39);
    check("R8 vblank lines", f_vb, 5);
    check("R8 vsync lines", f_vs, 1);
    check("R5 display dots per frame", f_de, 960);

    rst_n = 1'b0;
    set_v(39, 29, 35, 2, 5, 5);
    do_reset();
    wait_frame_start();
    measure_frame();
    check("R9 vblank lines across frame wrap", f_vb, 7);
    check("R8 vsync 16-line maximum", f_vs, 16);

    // R10: mid-frame change of totals
    rst_n = 1'b0;
    set_v(39, 29, 30, 35, 32, 33);
    do_reset();
    do @(negedge clk); while (!(line_cnt == 10'd10 && char_cnt == 9'd0 && dot_cnt == 4'd0));
    h_total = 8'd2;
    v_total = 10'd9;
    wait_line_start();
    measure_line();
    check("R10 line length unchanged mid-frame", m_dots, 40);
    f_maxline = 0;
    do begin
      if (int'(line_cnt) > f_maxline) f_maxline = int'(line_cnt);
      @(negedge clk);
    end while (!(line_cnt == 10'd0 && char_cnt == 9'd0 && dot_cnt == 4'd0));
    check("R10 old frame reaches old total", f_maxline, 39);
    measure_frame();
    check("R10 new frame dots", f_dots, 560);
    check("R10 new frame lines", f_lines, 10);

    // R1: reset applied mid-run
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("midrun");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule